// File: doc/BRIEF.md
# Inductive converter switch-phase sequencer

This block is the digital heart of a pulsed inductive DC/DC converter that supplies a card socket. It steers three pairs of power-switch gates through a repeating cycle. In the charge phase pair A stores energy in the inductor until the peak-current comparator trips. In the dump phase pair B moves that energy into the output for a fixed time. In the clamp phase pair C shorts out the inductor once the output reaches its target. One all-off dead cycle sits between any two phases, so two pairs are never on in the same cycle.

A two-bit level code picks the output target and tells the current comparator which peak threshold to use. When the code is zero or the enable/card-present input drops, every gate turns off and the output pull-down is driven. A charge phase that never reaches peak current is cut short by a watchdog, which latches a fault. The fault is cleared only by disabling the block.

States and transitions:
- OFF → GAP_CHG when enabled with a nonzero code.
- GAP_CHG → CHARGE.
- CHARGE → GAP_DUMP when the peak flag is seen.
- CHARGE → FAULT when the watchdog expires.
- GAP_DUMP → DUMP.
- DUMP → GAP_CLAMP when the regulation flag is seen.
- DUMP → GAP_CHG when the dump timer ends.
- GAP_CLAMP → CLAMP.
- CLAMP → GAP_CHG when the regulation flag drops.
- Any state → OFF when the block is disabled.

Top module: `inductive_phase_seq`

## Requirements
- R1: After reset all three gate enables are low and the pull-down is high. This holds until en_i is high and level_i is nonzero.
- R2: level_i encodes the target: 2'b00 = 0 V (switching disabled), 2'b01 = 1.8 V, 2'b10 = 3.0 V, 2'b11 = 5.0 V. While the block is active, peak_sel_o equals level_i. Otherwise peak_sel_o is 2'b00.
- R3: In CHARGE only gate_a_o is high. A high peak_i ends CHARGE at the next clock.
- R4: If peak_i stays low for TIMEOUT_NS*1000/CLK_PERIOD_PS consecutive CHARGE cycles, the block enters FAULT. In FAULT fault_o is high, all gates are low and the pull-down is high.
- R5: FAULT is sticky. peak_i and reg_ok_i have no effect on it. Only disabling the block (en_i low or level_i zero) clears fault_o.
- R6: In DUMP only gate_b_o is high, for exactly DUMP_NS*1000/CLK_PERIOD_PS cycles when reg_ok_i stays low. A dead cycle and a new CHARGE follow.
- R7: A high reg_ok_i during DUMP turns gate_b_o off at the next clock, without waiting for the dump timer. gate_c_o turns on one dead cycle later.
- R8: CLAMP keeps gate_c_o high while reg_ok_i is high. When reg_ok_i goes low, a dead cycle and a new CHARGE follow.
- R9: At most one gate enable is high in any cycle. A gate rises only after a cycle in which all gates were low.
- R10: From any state, en_i low or level_i zero makes all gates low and pull_dn_o high at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_PERIOD_PS |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable / card present |
| level_i | input | 2 | Output level code (R2) |
| peak_i | input | 1 | Peak-current comparator flag, synchronous |
| reg_ok_i | input | 1 | Output-at-target comparator flag, synchronous |
| gate_a_o | output | 1 | Charge pair enable |
| gate_b_o | output | 1 | Dump pair enable |
| gate_c_o | output | 1 | Clamp pair enable |
| pull_dn_o | output | 1 | Active output pull-down enable |
| fault_o | output | 1 | Sticky charge-timeout fault |
| peak_sel_o | output | 2 | Peak-current threshold select for the comparator |

## Verification
The assertions assume that both comparator flags are already synchronous to clk and change only between edges. They also assume that the peak flag is meaningful only during the charge phase. The bench drives every input on the falling edge and raises the peak flag only while pair A is on. It raises the regulation flag only during the dump or clamp phases, except for the deliberate checks that FAULT ignores both flags. The charge watchdog is set short in the bench, and the dump length keeps its real 900 ns, so that both timers are swept to their exact cycle counts.

// File: rtl/inductive_phase_seq_pkg.sv
package inductive_phase_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF       = 4'd0,
        ST_GAP_CHG   = 4'd1,
        ST_CHARGE    = 4'd2,
        ST_GAP_DUMP  = 4'd3,
        ST_DUMP      = 4'd4,
        ST_GAP_CLAMP = 4'd5,
        ST_CLAMP     = 4'd6,
        ST_FAULT     = 4'd7
    } seq_state_t;

    typedef logic [1:0] level_code_t;

    localparam level_code_t LVL_ZERO = 2'b00;
    localparam level_code_t LVL_1V8  = 2'b01;
    localparam level_code_t LVL_3V0  = 2'b10;
    localparam level_code_t LVL_5V0  = 2'b11;

    typedef struct packed {
        logic gate_a;
        logic gate_b;
        logic gate_c;
        logic pull_dn;
        logic fault;
    } drive_t;

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int LIMIT = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts cycles spent in the owning phase; cleared whenever it leaves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/seq_level_decode.sv
module seq_level_decode
    import inductive_phase_seq_pkg::*;
(
    input  logic        en_i,
    input  level_code_t level_i,
    output logic        active_o,
    output level_code_t peak_sel_o
);
    always_comb begin
        active_o   = en_i && (level_i != LVL_ZERO);
        peak_sel_o = active_o ? level_i : LVL_ZERO;
    end
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
    import inductive_phase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active_i,
    input  logic   peak_i,
    input  logic   reg_ok_i,
    input  logic   dump_done_i,
    input  logic   tmo_done_i,
    output logic   in_charge_o,
    output logic   in_dump_o,
    output drive_t drv_o
);
    seq_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transition logic; disabling overrides every other transition
    always_comb begin
        state_d = state_q;
        if (!active_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_GAP_CHG;
                ST_GAP_CHG:   state_d = ST_CHARGE;
                ST_CHARGE: begin
                    if (peak_i)          state_d = ST_GAP_DUMP;
                    else if (tmo_done_i) state_d = ST_FAULT;
                end
                ST_GAP_DUMP:  state_d = ST_DUMP;
                ST_DUMP: begin
                    if (reg_ok_i)         state_d = ST_GAP_CLAMP;
                    else if (dump_done_i) state_d = ST_GAP_CHG;
                end
                ST_GAP_CLAMP: state_d = ST_CLAMP;
                ST_CLAMP: begin
                    if (!reg_ok_i) state_d = ST_GAP_CHG;
                end
                ST_FAULT:     state_d = ST_FAULT;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    // Output decode from the registered state
    always_comb begin
        drv_o = '0;
        unique case (state_q)
            ST_OFF:       drv_o.pull_dn = 1'b1;
            ST_CHARGE:    drv_o.gate_a  = 1'b1;
            ST_DUMP:      drv_o.gate_b  = 1'b1;
            ST_CLAMP:     drv_o.gate_c  = 1'b1;
            ST_FAULT: begin
                drv_o.fault   = 1'b1;
                drv_o.pull_dn = 1'b1;
            end
            ST_GAP_CHG, ST_GAP_DUMP, ST_GAP_CLAMP: drv_o = '0;
            default:      drv_o.pull_dn = 1'b1;
        endcase
    end

    assign in_charge_o = (state_q == ST_CHARGE);
    assign in_dump_o   = (state_q == ST_DUMP);
endmodule

// File: rtl/inductive_phase_seq.sv
module inductive_phase_seq
    import inductive_phase_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int DUMP_NS       = 900,
    parameter int TIMEOUT_NS    = 4000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] level_i,
    input  logic       peak_i,
    input  logic       reg_ok_i,
    output logic       gate_a_o,
    output logic       gate_b_o,
    output logic       gate_c_o,
    output logic       pull_dn_o,
    output logic       fault_o,
    output logic [1:0] peak_sel_o
);
    localparam longint DUMP_RAW = (longint'(DUMP_NS) * 1000) / CLK_PERIOD_PS;
    localparam longint TMO_RAW  = (longint'(TIMEOUT_NS) * 1000) / CLK_PERIOD_PS;
    localparam int DUMP_CYC = (DUMP_RAW < 1) ? 1 : int'(DUMP_RAW);
    localparam int TMO_CYC  = (TMO_RAW < 1) ? 1 : int'(TMO_RAW);

    logic   active;
    logic   in_charge, in_dump;
    logic   dump_done, tmo_done;
    drive_t drv;

    seq_level_decode u_level (
        .en_i       (en_i),
        .level_i    (level_i),
        .active_o   (active),
        .peak_sel_o (peak_sel_o)
    );

    seq_phase_timer #(.LIMIT(DUMP_CYC)) u_dump_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_dump),
        .done  (dump_done)
    );

    seq_phase_timer #(.LIMIT(TMO_CYC)) u_chg_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_charge),
        .done  (tmo_done)
    );

    seq_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .peak_i      (peak_i),
        .reg_ok_i    (reg_ok_i),
        .dump_done_i (dump_done),
        .tmo_done_i  (tmo_done),
        .in_charge_o (in_charge),
        .in_dump_o   (in_dump),
        .drv_o       (drv)
    );

    assign gate_a_o  = drv.gate_a;
    assign gate_b_o  = drv.gate_b;
    assign gate_c_o  = drv.gate_c;
    assign pull_dn_o = drv.pull_dn;
    assign fault_o   = drv.fault;
endmodule

// File: rtl/inductive_phase_seq_chk.sv
module inductive_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [1:0] level_i,
    input logic       peak_i,
    input logic       reg_ok_i,
    input logic       gate_a_o,
    input logic       gate_b_o,
    input logic       gate_c_o,
    input logic       pull_dn_o,
    input logic       fault_o,
    input logic [1:0] peak_sel_o
);
    logic act;
    assign act = en_i && (level_i != 2'b00);

    // R9
    one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gate_a_o, gate_b_o, gate_c_o}) <= 1);

    // R9
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_a_o) || $rose(gate_b_o) || $rose(gate_c_o))
            |-> $past({gate_a_o, gate_b_o, gate_c_o}) == 3'b000);

    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (pull_dn_o && !gate_a_o && !gate_b_o && !gate_c_o));

    // R5
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && act) |=> fault_o);

    // R7
    reg_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_b_o && reg_ok_i && act) |=> (!gate_b_o && !gate_c_o));

    // R3
    peak_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a_o && peak_i && act) |=> !gate_a_o);

    // R2
    peak_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_sel_o == (act ? level_i : 2'b00));
endmodule

bind inductive_phase_seq inductive_phase_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .level_i    (level_i),
    .peak_i     (peak_i),
    .reg_ok_i   (reg_ok_i),
    .gate_a_o   (gate_a_o),
    .gate_b_o   (gate_b_o),
    .gate_c_o   (gate_c_o),
    .pull_dn_o  (pull_dn_o),
    .fault_o    (fault_o),
    .peak_sel_o (peak_sel_o)
);

// File: tb/inductive_phase_seq_bench.sv
`timescale 1ns/1ps
module inductive_phase_seq_bench;
    localparam int PER_PS  = 5000;
    localparam int DUMP_NS = 900;
    localparam int TMO_NS  = 2000;
    localparam int EXP_DUMP = DUMP_NS * 1000 / PER_PS;
    localparam int EXP_TMO  = TMO_NS * 1000 / PER_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic [1:0] level_i = 2'b00;
    logic peak_i = 1'b0;
    logic reg_ok_i = 1'b0;
    logic gate_a_o, gate_b_o, gate_c_o, pull_dn_o, fault_o;
    logic [1:0] peak_sel_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    inductive_phase_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .DUMP_NS       (DUMP_NS),
        .TIMEOUT_NS    (TMO_NS)
    ) u_inductive_phase_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .level_i(level_i),
        .peak_i(peak_i), .reg_ok_i(reg_ok_i),
        .gate_a_o(gate_a_o), .gate_b_o(gate_b_o), .gate_c_o(gate_c_o),
        .pull_dn_o(pull_dn_o), .fault_o(fault_o), .peak_sel_o(peak_sel_o)
    );

    function automatic logic [4:0] outs();
        return {gate_a_o, gate_b_o, gate_c_o, pull_dn_o, fault_o};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare {a,b,c,pd,fault}
    task automatic chk_outs(input logic [4:0] exp, input string req);
        chk(outs() === exp, req, int'(outs()), int'(exp));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [4:0] O_OFF   = 5'b00010;
    localparam logic [4:0] O_GAP   = 5'b00000;
    localparam logic [4:0] O_A     = 5'b10000;
    localparam logic [4:0] O_B     = 5'b01000;
    localparam logic [4:0] O_C     = 5'b00100;
    localparam logic [4:0] O_FAULT = 5'b00011;

    // R9: exclusivity watched on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk($countones({gate_a_o, gate_b_o, gate_c_o}) <= 1, "R9",
                int'({gate_a_o, gate_b_o, gate_c_o}), 0);
        end
    end

    // Drives from OFF to phase p: 0 charge, 1 dump, 2 clamp
    task automatic go_phase(input int p);
        en_i = 1'b1; level_i = 2'b01; tick(2);
        if (p >= 1) begin
            peak_i = 1'b1; tick(1); peak_i = 1'b0; tick(1);
        end
        if (p == 2) begin
            reg_ok_i = 1'b1; tick(2);
        end
    endtask

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk_outs(O_OFF, "R1 reset");
        en_i = 1'b1; level_i = 2'b00; tick(3);
        chk_outs(O_OFF, "R1 zero code");
        chk(peak_sel_o == 2'b00, "R2 off sel", peak_sel_o, 0);
        en_i = 1'b0; level_i = 2'b01; tick(3);
        chk_outs(O_OFF, "R1 no enable");

        // start-up: gap then charge
        en_i = 1'b1; tick(1);
        chk_outs(O_GAP, "R9 gap before charge");
        tick(1);
        chk_outs(O_A, "R3 charge");
        chk(peak_sel_o == 2'b01, "R2 sel", peak_sel_o, 1);
        tick(5);
        chk_outs(O_A, "R3 charge hold");
        peak_i = 1'b1; tick(1);
        chk_outs(O_GAP, "R3 peak ends charge");
        peak_i = 1'b0; tick(1);
        n = 0;
        while (gate_b_o && n < 1000) begin n++; tick(1); end
        chk(n == EXP_DUMP, "R6 dump length", n, EXP_DUMP);
        chk_outs(O_GAP, "R6 gap after dump");
        tick(1);
        chk_outs(O_A, "R6 recharge");

        // regulation cut during dump
        peak_i = 1'b1; tick(1); peak_i = 1'b0; tick(1);
        chk_outs(O_B, "R6 dump");
        tick(3);
        reg_ok_i = 1'b1; tick(1);
        chk_outs(O_GAP, "R7 early cut");
        tick(1);
        chk_outs(O_C, "R7 clamp on");
        tick(20);
        chk_outs(O_C, "R8 clamp hold");
        reg_ok_i = 1'b0; tick(1);
        chk_outs(O_GAP, "R8 gap");
        tick(1);
        chk_outs(O_A, "R8 recharge");

        // level code sweep in charge
        for (int l = 1; l < 4; l++) begin
            level_i = 2'(l); tick(1);
            chk(peak_sel_o == 2'(l), "R2 sweep", peak_sel_o, l);
            chk_outs(O_A, "R2 sweep charge");
        end

        // watchdog timeout
        en_i = 1'b0; tick(1);
        chk_outs(O_OFF, "R10 disable");
        en_i = 1'b1; tick(2);
        n = 0;
        while (gate_a_o && n < 100000) begin n++; tick(1); end
        chk(n == EXP_TMO, "R4 timeout length", n, EXP_TMO);
        chk_outs(O_FAULT, "R4 fault");
        peak_i = 1'b1; reg_ok_i = 1'b1; tick(5);
        chk_outs(O_FAULT, "R5 flags ignored");
        peak_i = 1'b0; reg_ok_i = 1'b0; tick(3);
        chk_outs(O_FAULT, "R5 sticky");
        level_i = 2'b00; tick(1);
        chk_outs(O_OFF, "R5 cleared by zero code");
        level_i = 2'b10; tick(2);
        chk_outs(O_A, "R5 restart");
        en_i = 1'b0; tick(1);

        // disable from every phase, both ways
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 3; p++) begin
                go_phase(p);
                chk_outs(p == 0 ? O_A : (p == 1 ? O_B : O_C), "R10 phase reached");
                if (m == 0) en_i = 1'b0; else level_i = 2'b00;
                tick(1);
                chk_outs(O_OFF, "R10 disable from phase");
                reg_ok_i = 1'b0; en_i = 1'b0; tick(2);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule